// File: doc/BRIEF.md
# Call-Progress Tone Generator

This block produces the dial, busy and ringback tones that a digital exchange places onto its serial PCM highway. All three tones use one 450 Hz waveform sampled at 8 kHz. The waveform lives in a 160-entry table that already holds companded (mu-law) codes. Because 160 samples span exactly nine tone periods, the table loops without a phase jump. A single phase counter steps through the table once per frame. In each selected slot, the current code goes out serially, most significant bit first.

The tones differ only in their on/off cadence. Each tone kind has its own frame-counting timer. During an off period that tone sends the silence code instead of the table sample. The host programs one slot-select mask per tone kind. Each selected slot gets a gated driver for that tone, and the output enable is raised only for the bits of that slot. When several tones claim the same slot, the tone with the lowest index wins.

The highway timing comes in from outside as a bit strobe and a frame marker. Each output bit is registered on the strobe edge that carries its bit position.

Top module: `callToneGen`

## Requirements
- R1: After reset, `pcmTx` and `pcmTxEn` are 0 and all three slot masks are zero, so no slot carries a tone.
- R2: In every bit period of a slot that no mask selects, `pcmTxEn` is 0 and `pcmTx` is 0.
- R3: The frame marker is sampled with the bit strobe and marks bit 0 of slot 0. Each later strobe advances one bit, eight bits per slot. The output for a bit position is registered on the strobe edge of that position. In a selected slot, `pcmTxEn` is 1 for all eight bits, and the eight code bits go out most significant bit first.
- R4: Frame n counts the frame markers since reset, starting at 0. Frame n carries table entry a = n mod 160. Entry a is the mu-law code of the linear value ±(PEAK·4t/(8000−t)), where p = 9a mod 160, h = p mod 80 and t = h·(80−h). The sign is negative for p ≥ 80. Encoding: b = |v|+33; the segment is the index of the top set bit of b minus 5; the mantissa is bits [seg+4:seg+1] of b; code = ~{sign, seg, mantissa}.
- R5: The table address wraps after entry 159, so frame 160 carries the same code as frame 0.
- R6: Dial tone (mask index 0) is never in an off period.
- R7: Busy tone (mask index 1) is on for BUSY_ON frames and then off for BUSY_OFF frames, repeating. While it is off, its slots carry 0xFF.
- R8: Ringback (mask index 2) is on for RING_ON frames and then off for RING_OFF frames, repeating. While it is off, its slots carry 0xFF.
- R9: When a slot is selected by more than one mask, the tone with the lower index is sent.
- R10: Writing a nonzero mask to a tone whose mask is zero restarts that tone's cadence. The next frame is the first frame of an on period. Writing a nonzero mask over a nonzero mask leaves the cadence running.
- R11: While `bitEn` is low, `pcmTx` and `pcmTxEn` hold, and the bit, slot and frame position does not advance.
- R12: A write to address 3 changes no mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameSync | input | 1 | Frame marker, sampled with `bitEn`; marks slot 0 bit 0 |
| bitEn | input | 1 | One-cycle strobe per highway bit |
| wrEn | input | 1 | Host mask write strobe |
| wrAddr | input | 2 | Mask select: 0 dial, 1 busy, 2 ringback, 3 unused |
| wrData | input | NUM_SLOTS | Slot mask, bit s selects slot s |
| pcmTx | output | 1 | Serial tone data |
| pcmTxEn | output | 1 | Drive enable for `pcmTx` |

## Verification
The bound checker watches several rules on every cycle. It checks that data is never high without the enable, and that the outputs hold through strobe gaps. It checks that the enable changes only on a slot's first bit. It also checks that a write to the unused address leaves the masks untouched, and that dial tone is on at every frame start. Only the directed scenarios can show the rest. These cover the exact sample sequence and its wrap after 160 frames, the busy and ringback cadence lengths, slot priority between overlapping masks, and when a mask write restarts a cadence and when it does not. The bench compares each slot's byte against its own table and cadence model.

// File: rtl/toneGenPkg.sv
package toneGenPkg;
  localparam int NUM_TONES  = 3;
  localparam int TABLE_LEN  = 160;
  localparam int TABLE_STEP = 9;
  localparam int HALF_LEN   = TABLE_LEN / 2;
  localparam int SEL_W      = 2;
  localparam logic [7:0] SILENCE = 8'hFF;

  typedef enum logic [SEL_W-1:0] {
    TONE_DIAL = 2'd0,
    TONE_BUSY = 2'd1,
    TONE_RING = 2'd2
  } toneKind_e;

  typedef struct packed {
    logic                 frameStart;
    logic                 slotLoad;
    logic                 bitStep;
    logic [NUM_TONES-1:0] toneOn;
    logic [NUM_TONES-1:0] slotHit;
  } toneStrobe_t;

  function automatic logic [7:0] muEncode(input int lin);
    int   mag;
    int   biased;
    int   seg;
    int   mant;
    logic neg;
    neg = (lin < 0);
    mag = neg ? -lin : lin;
    if (mag > 8158) mag = 8158;
    biased = mag + 33;
    seg = 0;
    for (int i = 0; i < 7; i++) begin
      if (biased >= (64 << i)) seg = i + 1;
    end
    mant = (biased >> (seg + 1)) & 15;
    return ~{neg, seg[2:0], mant[3:0]};
  endfunction

  function automatic logic [7:0] toneSample(input int addr, input int peak);
    int p;
    int h;
    int t;
    int mag;
    p   = (addr * TABLE_STEP) % TABLE_LEN;
    h   = (p < HALF_LEN) ? p : p - HALF_LEN;
    t   = h * (HALF_LEN - h);
    mag = (peak * 4 * t) / (HALF_LEN * 100 - t);
    return muEncode((p < HALF_LEN) ? mag : -mag);
  endfunction
endpackage

// File: rtl/toneCtrl.sv
module toneCtrl
  import toneGenPkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int BUSY_ON   = 2800,
  parameter int BUSY_OFF  = 2800,
  parameter int RING_ON   = 8000,
  parameter int RING_OFF  = 32000
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           frameSync,
  input  logic                           bitEn,
  input  logic                           wrEn,
  input  logic [SEL_W-1:0]               wrAddr,
  input  logic [NUM_SLOTS-1:0]           wrData,
  output toneStrobe_t                    strb,
  output logic [NUM_TONES*NUM_SLOTS-1:0] maskFlat
);
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int CAD_W  = $clog2(BUSY_ON + BUSY_OFF + RING_ON + RING_OFF + 2);
  localparam int ON_LEN  [NUM_TONES] = '{1, BUSY_ON, RING_ON};
  localparam int OFF_LEN [NUM_TONES] = '{0, BUSY_OFF, RING_OFF};

  logic [2:0]          bitCnt;
  logic [SLOT_W-1:0]   slotCnt;
  logic [2:0]          curBit;
  logic [SLOT_W-1:0]   curSlot;
  logic                frameStart;
  logic [NUM_TONES-1:0] toneOnV;
  logic [NUM_TONES-1:0] slotHitV;

  assign curBit     = frameSync ? 3'd0 : bitCnt;
  assign curSlot    = frameSync ? '0 : slotCnt;
  assign frameStart = bitEn & frameSync;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt  <= 3'd0;
      slotCnt <= '0;
    end else if (bitEn) begin
      if (curBit == 3'd7) begin
        bitCnt  <= 3'd0;
        slotCnt <= (curSlot == SLOT_W'(NUM_SLOTS - 1)) ? '0 : curSlot + SLOT_W'(1);
      end else begin
        bitCnt  <= curBit + 3'd1;
        slotCnt <= curSlot;
      end
    end
  end

  for (genvar g = 0; g < NUM_TONES; g++) begin : g_tone
    logic [NUM_SLOTS-1:0] maskReg;
    logic                 wrHit;
    logic                 restart;

    assign wrHit   = wrEn && (wrAddr == SEL_W'(g));
    assign restart = wrHit && (maskReg == '0) && (wrData != '0);

    always_ff @(posedge clk) begin
      if (!rstN) maskReg <= '0;
      else if (wrHit) maskReg <= wrData;
    end

    assign maskFlat[g*NUM_SLOTS +: NUM_SLOTS] = maskReg;
    assign slotHitV[g] = maskReg[curSlot];

    if (OFF_LEN[g] == 0) begin : g_steady
      assign toneOnV[g] = 1'b1;
    end else begin : g_cadence
      localparam int PERIOD = ON_LEN[g] + OFF_LEN[g];
      logic [CAD_W-1:0] cadCnt;
      always_ff @(posedge clk) begin
        if (!rstN || restart) cadCnt <= '0;
        else if (frameStart)
          cadCnt <= (cadCnt == CAD_W'(PERIOD - 1)) ? '0 : cadCnt + CAD_W'(1);
      end
      assign toneOnV[g] = (cadCnt < CAD_W'(ON_LEN[g]));
    end
  end

  always_comb begin
    strb.frameStart = frameStart;
    strb.slotLoad   = bitEn & (curBit == 3'd0);
    strb.bitStep    = bitEn;
    strb.toneOn     = toneOnV;
    strb.slotHit    = slotHitV;
  end
endmodule

// File: rtl/toneData.sv
module toneData
  import toneGenPkg::*;
#(
  parameter int PEAK = 2000
) (
  input  logic        clk,
  input  logic        rstN,
  input  toneStrobe_t strb,
  output logic        pcmTx,
  output logic        pcmTxEn
);
  localparam int ADDR_W = $clog2(TABLE_LEN);

  logic [7:0]        romTbl [TABLE_LEN];
  logic [ADDR_W-1:0] addr;
  logic [7:0]        freshCode;
  logic [NUM_TONES-1:0] serBit;
  logic [NUM_TONES-1:0] act;
  logic              winBit;
  logic              winAct;

  for (genvar a = 0; a < TABLE_LEN; a++) begin : g_rom
    assign romTbl[a] = toneSample(a, PEAK);
  end

  assign freshCode = romTbl[addr];

  always_ff @(posedge clk) begin
    if (!rstN) addr <= '0;
    else if (strb.frameStart)
      addr <= (addr == ADDR_W'(TABLE_LEN - 1)) ? '0 : addr + ADDR_W'(1);
  end

  for (genvar g = 0; g < NUM_TONES; g++) begin : g_drv
    logic [7:0] frameCode;
    logic [7:0] gatedCode;
    logic [7:0] loadCode;
    logic [7:0] shiftReg;
    logic       gateEn;

    assign gatedCode = strb.toneOn[g] ? freshCode : SILENCE;
    assign loadCode  = strb.frameStart ? gatedCode : frameCode;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        frameCode <= SILENCE;
        shiftReg  <= '0;
        gateEn    <= 1'b0;
      end else begin
        if (strb.frameStart) frameCode <= gatedCode;
        if (strb.slotLoad) begin
          shiftReg <= {loadCode[6:0], 1'b0};
          gateEn   <= strb.slotHit[g];
        end else if (strb.bitStep) begin
          shiftReg <= {shiftReg[6:0], 1'b0};
        end
      end
    end

    assign serBit[g] = strb.slotLoad ? loadCode[7] : shiftReg[7];
    assign act[g]    = strb.slotLoad ? strb.slotHit[g] : gateEn;
  end

  always_comb begin
    winAct = 1'b0;
    winBit = 1'b0;
    for (int t = NUM_TONES - 1; t >= 0; t--) begin
      if (act[t]) begin
        winAct = 1'b1;
        winBit = serBit[t];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcmTx   <= 1'b0;
      pcmTxEn <= 1'b0;
    end else if (strb.bitStep) begin
      pcmTxEn <= winAct;
      pcmTx   <= winAct & winBit;
    end
  end
endmodule

// File: rtl/callToneGen.sv
module callToneGen
  import toneGenPkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int BUSY_ON   = 2800,
  parameter int BUSY_OFF  = 2800,
  parameter int RING_ON   = 8000,
  parameter int RING_OFF  = 32000,
  parameter int PEAK      = 2000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 frameSync,
  input  logic                 bitEn,
  input  logic                 wrEn,
  input  logic [1:0]           wrAddr,
  input  logic [NUM_SLOTS-1:0] wrData,
  output logic                 pcmTx,
  output logic                 pcmTxEn
);
  toneStrobe_t                    strb;
  logic [NUM_TONES*NUM_SLOTS-1:0] maskFlat;

  toneCtrl #(
    .NUM_SLOTS(NUM_SLOTS), .BUSY_ON(BUSY_ON), .BUSY_OFF(BUSY_OFF),
    .RING_ON(RING_ON), .RING_OFF(RING_OFF)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .bitEn(bitEn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strb(strb), .maskFlat(maskFlat)
  );

  toneData #(.PEAK(PEAK)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb),
    .pcmTx(pcmTx), .pcmTxEn(pcmTxEn)
  );
endmodule

// File: rtl/callToneGenChk.sv
module callToneGenChk
  import toneGenPkg::*;
#(
  parameter int NUM_SLOTS = 32
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           bitEn,
  input logic                           wrEn,
  input logic [1:0]                     wrAddr,
  input logic                           pcmTx,
  input logic                           pcmTxEn,
  input toneStrobe_t                    strb,
  input logic [NUM_TONES*NUM_SLOTS-1:0] maskFlat
);
  // R2
  data_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pcmTxEn |-> !pcmTx);

  // R11
  strobe_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> ($stable(pcmTx) && $stable(pcmTxEn)));

  // R3
  slot_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pcmTxEn) |-> $past(strb.slotLoad));

  // R12
  bad_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 2'd3) |=> $stable(maskFlat));

  // R6
  dial_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameStart |-> strb.toneOn[0]);
endmodule

bind callToneGen callToneGenChk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk(clk), .rstN(rstN), .bitEn(bitEn), .wrEn(wrEn), .wrAddr(wrAddr),
  .pcmTx(pcmTx), .pcmTxEn(pcmTxEn), .strb(strb), .maskFlat(maskFlat)
);

// File: tb/tb_callToneGen.sv
module tb_callToneGen;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 32;
  localparam int PK = 2000;
  localparam int ON_L  [3] = '{1, 3, 2};
  localparam int OFF_L [3] = '{0, 3, 5};

  logic clk = 0;
  logic rstN = 0;
  logic frameSync = 0;
  logic bitEn = 0;
  logic wrEn = 0;
  logic [1:0] wrAddr = 0;
  logic [NS-1:0] wrData = 0;
  logic pcmTx;
  logic pcmTxEn;

  int vectors = 0;
  int miscompares = 0;
  int frameIdx = 0;
  int cadStart [3] = '{0, 0, 0};
  logic [NS-1:0] benchMask [3];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  callToneGen #(.NUM_SLOTS(NS), .BUSY_ON(3), .BUSY_OFF(3), .RING_ON(2),
                .RING_OFF(5), .PEAK(PK)) dut (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .bitEn(bitEn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pcmTx(pcmTx), .pcmTxEn(pcmTxEn));

  function automatic logic [7:0] benchMu(int v);
    int b;
    int seg = 0;
    int s = (v < 0) ? 1 : 0;
    b = ((v < 0) ? -v : v);
    if (b > 8158) b = 8158;
    b = b + 33;
    while ((b >> (seg + 6)) != 0) seg++;
    return 8'(255 - (s * 128 + seg * 16 + ((b >> (seg + 1)) % 16)));
  endfunction

  function automatic logic [7:0] benchCode(int a);
    int p = (9 * a) % 160;
    int h = p % 80;
    int t = h * (80 - h);
    int m = (PK * 4 * t) / (8000 - t);
    return benchMu((p >= 80) ? -m : m);
  endfunction

  function automatic logic [7:0] expCode(int t, int n);
    int rel = n - cadStart[t];
    bit on = (OFF_L[t] == 0) || ((rel % (ON_L[t] + OFF_L[t])) < ON_L[t]);
    return on ? benchCode(n % 160) : 8'hFF;
  endfunction

  task automatic chk(string tag, int slot, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s frame %0d slot %0d actual %h expected %h", tag, frameIdx, slot, got, exp);
    end
  endtask

  task automatic writeMask(int a, logic [NS-1:0] d);
    @(negedge clk);
    wrEn = 1; wrAddr = 2'(a); wrData = d;
    @(negedge clk);
    wrEn = 0;
    if (a < 3) begin
      if (benchMask[a] == 0 && d != 0) cadStart[a] = frameIdx;
      benchMask[a] = d;
    end
  endtask

  task automatic runFrame(string tag, bit gaps);
    logic [7:0] gotB [NS];
    logic [7:0] gotE [NS];
    bit holdOk = 1;
    for (int s = 0; s < NS; s++) begin
      for (int b = 0; b < 8; b++) begin
        @(negedge clk);
        frameSync = (s == 0 && b == 0); bitEn = 1;
        @(posedge clk); #1;
        gotB[s][7-b] = pcmTx; gotE[s][7-b] = pcmTxEn;
        if (gaps) begin
          for (int k = 0; k < 2; k++) begin
            logic pt = pcmTx;
            logic pe = pcmTxEn;
            @(negedge clk); frameSync = 0; bitEn = 0;
            @(posedge clk); #1;
            if (pcmTx !== pt || pcmTxEn !== pe) holdOk = 0;
          end
        end
      end
    end
    @(negedge clk); frameSync = 0; bitEn = 0;
    for (int s = 0; s < NS; s++) begin
      int w = -1;
      for (int t = 2; t >= 0; t--) if (benchMask[t][s]) w = t;
      if (w < 0) chk("R2", s, {gotE[s], gotB[s]}, 16'h0000);
      else chk((frameIdx >= 160) ? "R5" : tag, s, {gotE[s], gotB[s]}, {8'hFF, expCode(w, frameIdx)});
    end
    if (gaps) chk("R11", -1, 32'(holdOk), 32'd1);
    frameIdx++;
  endtask

  task automatic testReset();
    chk("R1", -1, {pcmTxEn, pcmTx}, 2'b00);
    runFrame("R1", 0);
  endtask

  task automatic testDial();
    writeMask(0, (NS'(1) << 1) | (NS'(1) << 5) | (NS'(1) << 31));
    for (int i = 0; i < 4; i++) runFrame("R6", 0);
    runFrame("R3", 0);
    runFrame("R4", 0);
  endtask

  task automatic testBusy();
    writeMask(1, (NS'(1) << 2) | (NS'(1) << 5));
    for (int i = 0; i < 8; i++) runFrame((i == 0) ? "R9" : "R7", 0);
  endtask

  task automatic testRing();
    writeMask(2, (NS'(1) << 2) | (NS'(1) << 3) | (NS'(1) << 5) | (NS'(1) << 7));
    runFrame("R9", 0);
    for (int i = 0; i < 8; i++) runFrame("R8", 0);
  endtask

  task automatic testRestart();
    runFrame("R10", 0);
    writeMask(1, (NS'(1) << 4));
    for (int i = 0; i < 3; i++) runFrame("R10", 0);
    writeMask(1, '0);
    runFrame("R10", 0);
    writeMask(1, (NS'(1) << 4) | (NS'(1) << 9));
    for (int i = 0; i < 5; i++) runFrame("R10", 0);
  endtask

  task automatic testBadAddr();
    writeMask(3, '1);
    runFrame("R12", 0);
  endtask

  task automatic testHold();
    runFrame("R11", 1);
  endtask

  task automatic testWrap();
    while (frameIdx < 166) runFrame("R4", 0);
  endtask

  initial begin
    for (int t = 0; t < 3; t++) benchMask[t] = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", -1, {pcmTxEn, pcmTx}, 2'b00);
    @(negedge clk); rstN = 1;
    testReset();
    testDial();
    testBusy();
    testRing();
    testRestart();
    testBadAddr();
    testHold();
    testWrap();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog frame %0d actual hung expected done", frameIdx);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule